// File: doc/BRIEF.md
# Serial Channel Interrupt and DMA Request Controller

This block sits beside one asynchronous serial channel and turns the channel's status events into one interrupt request and two DMA request lines. It latches four kinds of event: receive errors, a character landing in the receive buffer, the transmit buffer handing its character to the shift register, and a change on any modem control input. Each latched event stays pending until the register access that services it.

An enable register masks the pending events before they reach the interrupt line. A fixed-priority encoder turns the enabled pending set into a 3-bit identification code whose bit 0 is low while an interrupt is outstanding. Modem inputs come from the pins through a synchronizer. In loopback mode they come from register-driven values instead, and changes on those still count as modem events.

Each of the two DMA request lines has its own 2-bit source select. A line can follow the receive-full flag, follow the transmit-empty flag, or stay low. The receive-full request is blocked while any line error bit is set, so a damaged character is never moved by DMA.

Top module: `uart_irq_dma`

## Requirements
- R1: A synchronous active-high reset clears every pending flag, the enable register and both source selects. Afterwards the ID reads 001, the interrupt request is low and both DMA requests are low. An event that arrives after reset raises no interrupt until an enable bit is written.
- R2: A pulse on any bit of the 4-bit line error event input sets the line-status flag on that clock edge. Reading the line status register clears the flag.
- R3: A receive-load pulse sets the receive-full flag. Reading the receive buffer clears it.
- R4: A transmit-move pulse sets the transmit-empty flag. Writing the transmit holding register clears it. Reading the ID also clears it, but only while 010 is the reported ID.
- R5: In normal mode, a change on any of the 4 modem pins passes through two synchronizer flops. It sets the modem flag on the third rising edge after the pin changes. Reading the modem status register clears the flag.
- R6: In loopback mode, the modem value comes from the loopback input bits. A change on them sets the modem flag on the next edge, and pin changes are ignored.
- R7: The enable register has one bit per source: bit 0 line status, bit 1 receive full, bit 2 transmit empty, bit 3 modem. The interrupt request is high, and ID bit 0 is 0, exactly when some pending flag has its enable bit set.
- R8: Among enabled pending sources the ID is 110 for line status, 100 for receive full, 010 for transmit empty and 000 for modem, in that priority order. With none it is 001.
- R9: Each DMA line has a 2-bit select. Line 0 uses bits 1:0 of the select write data and line 1 uses bits 3:2. The codes are 00 low, 01 receive-full flag, 10 transmit-empty flag and 11 low. The DMA requests do not depend on the enable register.
- R10: While any bit of the 4-bit line error status input is set, a DMA line selecting receive full is held low. This takes effect in the same cycle.
- R11: When a set event and its clearing access arrive in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lineErrEvt | input | 4 | Pulses for overrun, parity, framing and break |
| rxLoadEvt | input | 1 | Pulse: character moved into the receive buffer |
| txMoveEvt | input | 1 | Pulse: transmit buffer moved to the shift register |
| modemPins | input | 4 | Asynchronous modem control inputs |
| loopEn | input | 1 | Loopback mode select |
| loopModem | input | 4 | Register-driven modem values used in loopback |
| lsrErr | input | 4 | Current line status error bits |
| lsrRd | input | 1 | Line status register read strobe |
| rbrRd | input | 1 | Receive buffer read strobe |
| thrWr | input | 1 | Transmit holding register write strobe |
| iidRd | input | 1 | Interrupt ID read strobe |
| msrRd | input | 1 | Modem status register read strobe |
| ierWr | input | 1 | Enable register write strobe |
| ierData | input | 4 | Enable register write data |
| selWr | input | 1 | DMA select write strobe |
| selData | input | 4 | DMA select write data, 2 bits per line |
| intId | output | 3 | Interrupt identification, bit 0 active low |
| intReq | output | 1 | Interrupt request |
| dreq | output | 2 | DMA request lines |

## Verification
The bench builds the block with its default parameters: four modem lines, four error bits, two DMA lines and a two-stage synchronizer. With these values the whole 16-way enable and pending space is small enough for a vector table to reach the priority encoding from many directions. The fixed three-edge pin latency can be checked edge by edge. The two DMA lines can be given opposite sources, so the receive-error blocking is seen on one line while the other keeps running.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef struct packed {
    logic clrLine;
    logic clrRx;
    logic clrTx;
    logic clrModem;
    logic wrIer;
    logic wrSel;
  } irqStrobe_t;

  localparam logic [2:0] ID_LINE  = 3'b110;
  localparam logic [2:0] ID_RX    = 3'b100;
  localparam logic [2:0] ID_TX    = 3'b010;
  localparam logic [2:0] ID_MODEM = 3'b000;
  localparam logic [2:0] ID_NONE  = 3'b001;

  localparam int SRC_N = 4;

  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_RX   = 2'b01,
    SEL_TX   = 2'b10,
    SEL_RSVD = 2'b11
  } dreqSel_e;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic       lsrRd,
  input  logic       rbrRd,
  input  logic       thrWr,
  input  logic       iidRd,
  input  logic       msrRd,
  input  logic       ierWr,
  input  logic       selWr,
  input  logic [2:0] curId,
  output irqStrobe_t stb
);

  always_comb begin
    stb.clrLine  = lsrRd;
    stb.clrRx    = rbrRd;
    // transmit-empty is serviced by a data write or by reading its own ID
    stb.clrTx    = thrWr | (iidRd & (curId == ID_TX));
    stb.clrModem = msrRd;
    stb.wrIer    = ierWr;
    stb.wrSel    = selWr;
  end

endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int MODEM_W     = 4,
  parameter int ERR_W       = 4,
  parameter int DREQ_N      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  irqStrobe_t            stb,
  input  logic [ERR_W-1:0]      lineErrEvt,
  input  logic                  rxLoadEvt,
  input  logic                  txMoveEvt,
  input  logic [MODEM_W-1:0]    modemPins,
  input  logic                  loopEn,
  input  logic [MODEM_W-1:0]    loopModem,
  input  logic [ERR_W-1:0]      lsrErr,
  input  logic [SRC_N-1:0]      ierData,
  input  logic [2*DREQ_N-1:0]   selData,
  output logic [2:0]            intId,
  output logic                  intReq,
  output logic [DREQ_N-1:0]     dreq
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [MODEM_W-1:0] syncQ [SYNC_STAGES];
  logic [MODEM_W-1:0] modemCur;
  logic [MODEM_W-1:0] modemPrev;
  logic               modemChg;
  logic [SRC_N-1:0]   pendQ;
  logic [SRC_N-1:0]   setVec;
  logic [SRC_N-1:0]   clrVec;
  logic [SRC_N-1:0]   ierQ;
  logic [SRC_N-1:0]   activeVec;
  logic [1:0]         selQ [DREQ_N];
  logic               rxDmaOk;

  // modem pin synchronizer
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
    end else begin
      syncQ[0] <= modemPins;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  assign modemCur = loopEn ? loopModem : syncQ[LAST_STAGE];
  assign modemChg = |(modemCur ^ modemPrev);

  always_ff @(posedge clk) begin
    if (rst) modemPrev <= '0;
    else     modemPrev <= modemCur;
  end

  // pending flags: set has priority over clear
  assign setVec = {modemChg, txMoveEvt, rxLoadEvt, |lineErrEvt};
  assign clrVec = {stb.clrModem, stb.clrTx, stb.clrRx, stb.clrLine};

  always_ff @(posedge clk) begin
    if (rst) pendQ <= '0;
    else     pendQ <= setVec | (pendQ & ~clrVec);
  end

  always_ff @(posedge clk) begin
    if (rst)            ierQ <= '0;
    else if (stb.wrIer) ierQ <= ierData;
  end

  // fixed priority encoder
  assign activeVec = pendQ & ierQ;
  assign intReq    = |activeVec;

  always_comb begin
    if      (activeVec[0]) intId = ID_LINE;
    else if (activeVec[1]) intId = ID_RX;
    else if (activeVec[2]) intId = ID_TX;
    else if (activeVec[3]) intId = ID_MODEM;
    else                   intId = ID_NONE;
  end

  // DMA request muxes
  assign rxDmaOk = pendQ[1] & ~(|lsrErr);

  for (genvar c = 0; c < DREQ_N; c++) begin : g_dreq
    always_ff @(posedge clk) begin
      if (rst)            selQ[c] <= SEL_OFF;
      else if (stb.wrSel) selQ[c] <= selData[2*c +: 2];
    end

    always_comb begin
      case (dreqSel_e'(selQ[c]))
        SEL_RX:  dreq[c] = rxDmaOk;
        SEL_TX:  dreq[c] = pendQ[2];
        default: dreq[c] = 1'b0;
      endcase
    end

    AST_RX_DMA_BLOCKED: assert property (@(posedge clk) disable iff (rst)
      (selQ[c] == SEL_RX && |lsrErr) |-> !dreq[c]); // R10
    AST_IDLE_SEL_LOW: assert property (@(posedge clk) disable iff (rst)
      (selQ[c] == SEL_OFF || selQ[c] == SEL_RSVD) |-> !dreq[c]); // R9
  end

  AST_NONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !intReq |-> intId == ID_NONE); // R7
  AST_LINE_TOP_PRIO: assert property (@(posedge clk) disable iff (rst)
    (pendQ[0] && ierQ[0]) |-> intId == ID_LINE); // R8
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    rxLoadEvt |=> pendQ[1]); // R11
  AST_RX_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (stb.clrRx && !rxLoadEvt) |=> !pendQ[1]); // R3
  AST_LINE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (stb.clrLine && lineErrEvt == '0) |=> !pendQ[0]); // R2

endmodule

// File: rtl/uart_irq_dma.sv
module uart_irq_dma
  import uart_irq_pkg::*;
#(
  parameter int MODEM_W     = 4,
  parameter int ERR_W       = 4,
  parameter int DREQ_N      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ERR_W-1:0]    lineErrEvt,
  input  logic                rxLoadEvt,
  input  logic                txMoveEvt,
  input  logic [MODEM_W-1:0]  modemPins,
  input  logic                loopEn,
  input  logic [MODEM_W-1:0]  loopModem,
  input  logic [ERR_W-1:0]    lsrErr,
  input  logic                lsrRd,
  input  logic                rbrRd,
  input  logic                thrWr,
  input  logic                iidRd,
  input  logic                msrRd,
  input  logic                ierWr,
  input  logic [SRC_N-1:0]    ierData,
  input  logic                selWr,
  input  logic [2*DREQ_N-1:0] selData,
  output logic [2:0]          intId,
  output logic                intReq,
  output logic [DREQ_N-1:0]   dreq
);

  irqStrobe_t stb;

  uart_irq_ctrl u_ctrl (
    .lsrRd (lsrRd),
    .rbrRd (rbrRd),
    .thrWr (thrWr),
    .iidRd (iidRd),
    .msrRd (msrRd),
    .ierWr (ierWr),
    .selWr (selWr),
    .curId (intId),
    .stb   (stb)
  );

  uart_irq_dp #(
    .MODEM_W     (MODEM_W),
    .ERR_W       (ERR_W),
    .DREQ_N      (DREQ_N),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .lineErrEvt (lineErrEvt),
    .rxLoadEvt  (rxLoadEvt),
    .txMoveEvt  (txMoveEvt),
    .modemPins  (modemPins),
    .loopEn     (loopEn),
    .loopModem  (loopModem),
    .lsrErr     (lsrErr),
    .ierData    (ierData),
    .selData    (selData),
    .intId      (intId),
    .intReq     (intReq),
    .dreq       (dreq)
  );

endmodule

// File: tb/uart_irq_dma_tb.sv
module uart_irq_dma_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] lineErrEvt = '0;
  logic       rxLoadEvt = 1'b0, txMoveEvt = 1'b0;
  logic [3:0] modemPins = '0, loopModem = '0, lsrErr = '0;
  logic       loopEn = 1'b0;
  logic       lsrRd = 0, rbrRd = 0, thrWr = 0, iidRd = 0, msrRd = 0;
  logic       ierWr = 0, selWr = 0;
  logic [3:0] ierData = '0, selData = '0;
  logic [2:0] intId;
  logic       intReq;
  logic [1:0] dreq;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  uart_irq_dma u_dut (
    .clk(clk), .rst(rst), .lineErrEvt(lineErrEvt), .rxLoadEvt(rxLoadEvt),
    .txMoveEvt(txMoveEvt), .modemPins(modemPins), .loopEn(loopEn),
    .loopModem(loopModem), .lsrErr(lsrErr), .lsrRd(lsrRd), .rbrRd(rbrRd),
    .thrWr(thrWr), .iidRd(iidRd), .msrRd(msrRd), .ierWr(ierWr),
    .ierData(ierData), .selWr(selWr), .selData(selData),
    .intId(intId), .intReq(intReq), .dreq(dreq)
  );

  // {enable[3:0], pending[3:0], expected id[2:0]}
  localparam logic [10:0] VEC [12] = '{
    {4'hF, 4'hF, 3'b110}, {4'hF, 4'hE, 3'b100}, {4'hF, 4'hC, 3'b010},
    {4'hF, 4'h8, 3'b000}, {4'hF, 4'h0, 3'b001}, {4'hE, 4'hF, 3'b100},
    {4'h5, 4'hA, 3'b001}, {4'h8, 4'h9, 3'b000}, {4'hC, 4'h7, 3'b010},
    {4'h1, 4'h1, 3'b110}, {4'h2, 4'hB, 3'b100}, {4'h0, 4'hF, 3'b001}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wrIer(logic [3:0] v);
    ierWr = 1; ierData = v; step(); ierWr = 0;
  endtask

  task automatic wrSel(logic [3:0] v);
    selWr = 1; selData = v; step(); selWr = 0;
  endtask

  task automatic clearAll();
    lsrRd = 1; rbrRd = 1; thrWr = 1; msrRd = 1; step();
    lsrRd = 0; rbrRd = 0; thrWr = 0; msrRd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); step(); rst = 0;
    check("R1 id after reset", {1'b0, intId}, 4'h1);
    check("R1 req after reset", {3'b0, intReq}, 4'h0);
    check("R1 dreq after reset", {2'b0, dreq}, 4'h0);

    loopEn = 1; step();
    // table walk: priority and masking (R7, R8)
    foreach (VEC[i]) begin
      wrIer(VEC[i][10:7]);
      lineErrEvt = VEC[i][3] ? 4'b0100 : 4'b0000;
      rxLoadEvt  = VEC[i][4];
      txMoveEvt  = VEC[i][5];
      if (VEC[i][6]) loopModem = ~loopModem;
      step();
      lineErrEvt = '0; rxLoadEvt = 0; txMoveEvt = 0;
      check("R8 table id", {1'b0, intId}, {1'b0, VEC[i][2:0]});
      check("R7 table req", {3'b0, intReq}, {3'b0, VEC[i][2:0] != 3'b001});
      clearAll();
      check("R8 cleared id", {1'b0, intId}, 4'h1);
    end

    // R2: each error bit alone
    wrIer(4'h1);
    for (int b = 0; b < 4; b++) begin
      lineErrEvt = 4'(1 << b); step(); lineErrEvt = '0;
      check("R2 error bit sets", {1'b0, intId}, 4'h6);
      lsrRd = 1; step(); lsrRd = 0;
      check("R2 lsr read clears", {1'b0, intId}, 4'h1);
    end

    // R4: ID read clears tx only while reported; R3 rx read clears
    wrIer(4'hF);
    txMoveEvt = 1; rxLoadEvt = 1; step(); txMoveEvt = 0; rxLoadEvt = 0;
    iidRd = 1; step(); iidRd = 0;
    check("R4 id read keeps hidden tx", {1'b0, intId}, 4'h4);
    rbrRd = 1; step(); rbrRd = 0;
    check("R3 rx read exposes tx", {1'b0, intId}, 4'h2);
    iidRd = 1; step(); iidRd = 0;
    check("R4 id read clears tx", {1'b0, intId}, 4'h1);
    txMoveEvt = 1; step(); txMoveEvt = 0;
    thrWr = 1; step(); thrWr = 0;
    check("R4 thr write clears", {1'b0, intId}, 4'h1);

    // R5: pin path, three edges
    loopEn = 0; step(); step(); step();
    msrRd = 1; step(); msrRd = 0;
    check("R5 quiet before pin", {1'b0, intId}, 4'h1);
    modemPins = 4'b0010;
    step(); check("R5 edge1", {1'b0, intId}, 4'h1);
    step(); check("R5 edge2", {1'b0, intId}, 4'h1);
    step(); check("R5 edge3", {1'b0, intId}, 4'h0);
    msrRd = 1; step(); msrRd = 0;
    check("R5 msr read clears", {1'b0, intId}, 4'h1);

    // R6: loopback ignores pins, reacts in one edge
    loopModem = 4'b0010; loopEn = 1; step();
    check("R6 no change on mode switch", {1'b0, intId}, 4'h1);
    modemPins = 4'b0000; step(); step(); step(); step();
    check("R6 pins ignored", {1'b0, intId}, 4'h1);
    loopModem = 4'b0011; step();
    check("R6 loop bit change", {1'b0, intId}, 4'h0);
    msrRd = 1; step(); msrRd = 0;

    // R11: set and clear together
    rxLoadEvt = 1; step(); rxLoadEvt = 0;
    rxLoadEvt = 1; rbrRd = 1; step(); rxLoadEvt = 0; rbrRd = 0;
    check("R11 set wins", {1'b0, intId}, 4'h4);

    // R9/R10: DMA
    wrSel(4'b1001);
    check("R9 ch0 rx ch1 tx", {2'b0, dreq}, 4'h1);
    txMoveEvt = 1; step(); txMoveEvt = 0;
    check("R9 both active", {2'b0, dreq}, 4'h3);
    lsrErr = 4'b0001; #1;
    check("R10 rx dma blocked", {2'b0, dreq}, 4'h2);
    lsrErr = 4'b1000; #1;
    check("R10 break blocks too", {2'b0, dreq}, 4'h2);
    lsrErr = '0; step();
    wrSel(4'b0110);
    check("R9 swapped select", {2'b0, dreq}, 4'h3);
    wrIer(4'h0);
    check("R9 dma ignores enables", {2'b0, dreq}, 4'h3);
    wrSel(4'b1111);
    check("R9 reserved code low", {2'b0, dreq}, 4'h0);

    // R1: reset clears flags, enables, selects
    wrSel(4'b1010); wrIer(4'hF);
    rst = 1; step(); rst = 0;
    check("R1 reset clears pending", {1'b0, intId}, 4'h1);
    check("R1 reset clears dreq", {2'b0, dreq}, 4'h0);
    rxLoadEvt = 1; txMoveEvt = 1; step(); rxLoadEvt = 0; txMoveEvt = 0;
    check("R1 enables cleared", {3'b0, intReq}, 4'h0);
    check("R1 selects cleared", {2'b0, dreq}, 4'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule